// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block carries out a single register access on a PHY control port that is reached indirectly. The port has one 32-bit command word driven toward the PHY and one 32-bit status word read back from it. A client raises a one-cycle request with a 16-bit register address and, for writes, 16-bit data. The block then runs a series of phases on the command word. Each phase places a value in the command field, then raises one strobe, waits for the PHY acknowledge to rise, lowers the strobe and waits for the acknowledge to fall.

Every access starts with an address phase. A write follows it with a data phase and then a commit phase. A read follows it with a single fetch phase, and the read data is captured while the acknowledge is high. The acknowledge may come from another clock domain, so it passes through a synchronizer before the sequencer acts on it. Each acknowledge wait has its own cycle budget. When a budget runs out, the access is abandoned, the command word goes back to zero and the read result is cleared. The access always ends with a one-cycle completion pulse, whether it succeeded or timed out.

Top module: `phy_reg_master`

## Requirements
- R1: After reset, and whenever `ready_o` is high, `cmd_o` is all-zero, `ready_o` is 1, and `done_o` and `timeout_o` are 0.
- R2: Command encoding. Bits 17:2 carry a 16-bit field. Bit 19 is the address-capture strobe, bit 18 the data-capture strobe, bit 1 the read strobe and bit 0 the write strobe. Every access first presents the address in the field with no strobe for at least `SETUP_CYCLES` cycles, then raises bit 19, so the PHY captures the full 16-bit address.
- R3: A write then presents the data with no strobe for at least `SETUP_CYCLES` cycles and handshakes with bit 18. After that it handshakes with bit 0, keeping the data in the field, so the PHY stores the data at the captured address.
- R4: A read then drives a field of zero and handshakes with bit 1 alone. `rdata_o` takes status bits 15:0 as they stand while the acknowledge (status bit 16) is seen high.
- R5: At most one strobe is high at any time, and the field does not change in the cycle a strobe rises.
- R6: The acknowledge passes through `SYNC_STAGES` (default 2) flip-flops. When the PHY raises its acknowledge, the strobe falls exactly three cycles later.
- R7: Each wait for an acknowledge edge lasts at most `TIMEOUT_CYCLES` cycles. When a wait expires, the access is abandoned: `cmd_o` returns to zero, and `done_o` and `timeout_o` pulse together with `rdata_o` equal to 0.
- R8: A request is taken only while `ready_o` is high. A request raised during an access has no effect.
- R9: `done_o` pulses for exactly one cycle at the end of each access. `timeout_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access (taken when idle) |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | PHY register address |
| wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Idle, able to take a request |
| done_o | output | 1 | One-cycle end-of-access pulse |
| timeout_o | output | 1 | Access abandoned on timeout (with done_o) |
| rdata_o | output | 16 | Data from the last read, 0 after a timeout |
| cmd_o | output | 32 | Command word toward the PHY |
| stat_i | input | 32 | Status word from the PHY (bit 16 ack, 15:0 data) |

## Verification
The bound checker watches, on every cycle, the properties that hold at each instant:
- the zero command word while idle,
- that strobes never overlap,
- that the field stays steady as a strobe rises,
- that the read field is zero,
- the single-cycle completion pulse,
- the cleared result on a timeout.

Other behaviour can only be shown by the bench's PHY model. That covers the phase order, whether the data really lands at the captured address, the exact three-cycle acknowledge latency, the exact cycle at which a silent or stuck PHY times out, and that a request raised mid-access is dropped.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;
  localparam int CMD_W  = 32;
  localparam int FLD_W  = 16;
  localparam int B_WR   = 0;
  localparam int B_RD   = 1;
  localparam int B_FLD  = 2;
  localparam int B_CAPD = 18;
  localparam int B_CAPA = 19;
  localparam int B_ACK  = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_RELEASE} st_e;
  typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_WRITE, PH_READ} ph_e;
endpackage

// File: rtl/phy_hs_sync.sv
module phy_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/phy_hs_timer.sv
module phy_hs_timer #(
  parameter int LIMIT = 250000,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/phy_hs_cmd_enc.sv
module phy_hs_cmd_enc
  import phy_hs_pkg::*;
(
  input  st_e              state_i,
  input  ph_e              phase_i,
  input  logic [FLD_W-1:0] addr_i,
  input  logic [FLD_W-1:0] data_i,
  output logic [CMD_W-1:0] cmd_o
);
  logic [FLD_W-1:0] fld;

  always_comb begin
    unique case (phase_i)
      PH_ADDR: fld = addr_i;
      PH_READ: fld = '0;
      default: fld = data_i;
    endcase
  end

  always_comb begin
    cmd_o = '0;
    if (state_i != ST_IDLE) begin
      cmd_o[B_FLD +: FLD_W] = fld;
      if (state_i == ST_STROBE) begin
        unique case (phase_i)
          PH_ADDR:  cmd_o[B_CAPA] = 1'b1;
          PH_DATA:  cmd_o[B_CAPD] = 1'b1;
          PH_WRITE: cmd_o[B_WR]   = 1'b1;
          default:  cmd_o[B_RD]   = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/phy_reg_master.sv
module phy_reg_master
  import phy_hs_pkg::*;
#(
  parameter int SETUP_CYCLES   = 2,
  parameter int TIMEOUT_CYCLES = 250000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic [15:0] wdata_i,
  output logic        ready_o,
  output logic        done_o,
  output logic        timeout_o,
  output logic [15:0] rdata_o,
  output logic [31:0] cmd_o,
  input  logic [31:0] stat_i
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYCLES - 1);

  st_e              state_q, state_d;
  ph_e              phase_q, phase_d;
  logic [FLD_W-1:0] addr_q, data_q, rdata_q;
  logic             we_q, done_q, tout_q;
  logic             ack_s, tmr_clr, tmr_exp;
  logic [CNT_W-1:0] tmr_cnt;
  logic             accept, fin, abort, latch;
  logic             unused_stat;

  assign unused_stat = ^stat_i[31:17];

  phy_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (stat_i[B_ACK]),
    .q_o   (ack_s)
  );

  phy_hs_timer #(.LIMIT(TIMEOUT_CYCLES), .CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .run_i    (state_q != ST_IDLE),
    .cnt_o    (tmr_cnt),
    .expired_o(tmr_exp)
  );

  phy_hs_cmd_enc u_enc (
    .state_i(state_q),
    .phase_i(phase_q),
    .addr_i (addr_q),
    .data_i (data_q),
    .cmd_o  (cmd_o)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    tmr_clr = 1'b0;
    accept  = 1'b0;
    fin     = 1'b0;
    abort   = 1'b0;
    latch   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept  = 1'b1;
        tmr_clr = 1'b1;
        state_d = ST_SETUP;
        phase_d = PH_ADDR;
      end
      ST_SETUP: if (tmr_cnt == SETUP_LAST) begin
        tmr_clr = 1'b1;
        state_d = ST_STROBE;
      end
      ST_STROBE: begin
        if (ack_s) begin
          latch   = (phase_q == PH_READ);
          tmr_clr = 1'b1;
          state_d = ST_RELEASE;
        end else if (tmr_exp) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RELEASE: begin
        if (!ack_s) begin
          tmr_clr = 1'b1;
          unique case (phase_q)
            PH_ADDR: begin
              state_d = ST_SETUP;
              phase_d = we_q ? PH_DATA : PH_READ;
            end
            PH_DATA: begin
              state_d = ST_SETUP;
              phase_d = PH_WRITE;
            end
            default: begin
              fin     = 1'b1;
              state_d = ST_IDLE;
            end
          endcase
        end else if (tmr_exp) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      addr_q  <= '0;
      data_q  <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done_q  <= fin | abort;
      tout_q  <= abort;
      if (accept) begin
        addr_q <= addr_i;
        data_q <= wdata_i;
        we_q   <= we_i;
      end
      if (abort)      rdata_q <= '0;
      else if (latch) rdata_q <= stat_i[FLD_W-1:0];
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tout_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/phy_hs_checker.sv
module phy_hs_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ready_o,
  input logic        done_o,
  input logic        timeout_o,
  input logic [15:0] rdata_o,
  input logic [31:0] cmd_o
);
  logic [3:0] strb;
  assign strb = {cmd_o[19], cmd_o[18], cmd_o[1], cmd_o[0]};

  a_r1_idle_cmd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cmd_o == 32'h0);

  a_r5_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb));

  a_r5_field_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|strb) |-> $stable(cmd_o[17:2]));

  a_r4_read_field_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[1] |-> cmd_o[17:2] == 16'h0);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_timeout_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);

  a_r7_timeout_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> rdata_o == 16'h0);

  a_r8_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
endmodule

bind phy_reg_master phy_hs_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_o  (ready_o),
  .done_o   (done_o),
  .timeout_o(timeout_o),
  .rdata_o  (rdata_o),
  .cmd_o    (cmd_o)
);

// File: tb/sim_phy_reg_master.sv
module sim_phy_reg_master;
  localparam int SETUP = 2;
  localparam int TMO   = 40;
  localparam int NV    = 8;

  // {we, addr, wdata, expected read data}
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 16'h0003, 16'h0000, 16'hA503},
    {1'b1, 16'h0003, 16'h1234, 16'h0000},
    {1'b0, 16'h0003, 16'h0000, 16'h1234},
    {1'b1, 16'h102D, 16'hFFFF, 16'h0000},
    {1'b0, 16'h102D, 16'h0000, 16'hFFFF},
    {1'b1, 16'hFFF0, 16'h0001, 16'h0000},
    {1'b0, 16'hFFF0, 16'h0000, 16'h0001},
    {1'b0, 16'h0007, 16'h0000, 16'hA507}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic        ready, done, tout;
  logic [15:0] rdata;
  logic [31:0] cmd, stat;

  always #2 clk = ~clk;

  phy_reg_master #(.SETUP_CYCLES(SETUP), .TIMEOUT_CYCLES(TMO), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .done_o(done), .timeout_o(tout),
    .rdata_o(rdata), .cmd_o(cmd), .stat_i(stat)
  );

  // PHY model, evaluated at falling edges
  logic        dead = 1'b0, stuck = 1'b0;
  logic        m_ack;
  logic [15:0] m_rd, cap_addr, cap_data, prev_fld;
  logic [15:0] mem [16];
  int m_cyc, t_rise, hold;
  bit gap_pend;
  int n_capa, n_capd, n_wr, n_rd, err_gap, err_setup, err_multi, err_rdfld;

  assign stat = {15'h0, m_ack, m_rd};

  always @(negedge clk) begin
    logic [3:0]  s;
    logic [15:0] f;
    if (!rst_n) begin
      m_ack = 1'b0; m_rd = '0; cap_addr = '0; cap_data = '0; prev_fld = '0;
      m_cyc = 0; t_rise = 0; hold = 0; gap_pend = 1'b0;
      n_capa = 0; n_capd = 0; n_wr = 0; n_rd = 0;
      err_gap = 0; err_setup = 0; err_multi = 0; err_rdfld = 0;
      for (int i = 0; i < 16; i++) mem[i] = 16'hA500 + 16'(i);
    end else begin
      m_cyc++;
      s = {cmd[19], cmd[18], cmd[1], cmd[0]};
      f = cmd[17:2];
      if (s == 4'h0) hold = (f == prev_fld) ? hold + 1 : 1;
      if ($countones(s) > 1) err_multi++;
      if (s != 4'h0 && !m_ack && !dead) begin
        if (hold < SETUP) err_setup++;
        if (s[3]) begin cap_addr = f; n_capa++; end
        if (s[2]) begin cap_data = f; n_capd++; end
        if (s[0]) begin mem[cap_addr[3:0]] = cap_data; n_wr++; end
        if (s[1]) begin
          if (f != 16'h0) err_rdfld++;
          m_rd = mem[cap_addr[3:0]]; n_rd++;
        end
        m_ack = 1'b1; t_rise = m_cyc; gap_pend = 1'b1;
      end
      if (s == 4'h0 && gap_pend) begin
        if (m_cyc - t_rise != 3) err_gap++;
        gap_pend = 1'b0;
      end
      if (s == 4'h0 && m_ack && !stuck) m_ack = 1'b0;
      prev_fld = f;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [15:0] d,
                        output int cyc, output logic to);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    cyc = 0; to = 1'b0;
    while (cyc < 4 * TMO + 50) begin
      @(negedge clk);
      req = 1'b0;
      cyc++;
      if (done) begin to = tout; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int cyc, a0, d0, w0, r0;
    logic to;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmd == 32'h0 && ready && !done && !tout && rdata == 16'h0, "R1", "reset state",
          {cmd[31:4], ready, done, tout, 1'b0}, 32'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic        vw;
      logic [15:0] va, vd, ve;
      {vw, va, vd, ve} = VEC[v];
      a0 = n_capa; d0 = n_capd; w0 = n_wr; r0 = n_rd;
      access(vw, va, vd, cyc, to);
      check(done && !to, "R9", "access completes without timeout", {31'h0, to}, 32'h0);
      check(cap_addr == va, "R2", "captured address", cap_addr, va);
      if (vw) begin
        check(mem[va[3:0]] == vd, "R3", "stored data", mem[va[3:0]], vd);
        check(n_capa - a0 == 1 && n_capd - d0 == 1 && n_wr - w0 == 1 && n_rd == r0,
              "R3", "write phase counts", {8'(n_capa-a0), 8'(n_capd-d0), 8'(n_wr-w0), 8'(n_rd-r0)},
              32'h01010100);
      end else begin
        check(rdata == ve, "R4", "read data", rdata, ve);
        check(n_capa - a0 == 1 && n_rd - r0 == 1 && n_capd == d0 && n_wr == w0,
              "R4", "read phase counts", {8'(n_capa-a0), 8'(n_capd-d0), 8'(n_wr-w0), 8'(n_rd-r0)},
              32'h01000001);
      end
      @(negedge clk);
      check(!done, "R9", "done lasts one cycle", {31'h0, done}, 32'h0);
      check(ready && cmd == 32'h0, "R1", "idle after access", cmd, 32'h0);
    end

    check(err_setup == 0, "R2", "field setup before strobe", err_setup, 0);
    check(err_multi == 0, "R5", "overlapping strobes", err_multi, 0);
    check(err_gap == 0, "R6", "ack to strobe-fall latency", err_gap, 0);
    check(err_rdfld == 0, "R4", "read field zero", err_rdfld, 0);

    // R8 request during busy access is dropped
    a0 = n_capa;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 16'h0005; wdata = 16'h5555;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    check(!ready, "R8", "busy during access", {31'h0, ready}, 32'h0);
    req = 1'b1; addr = 16'h0009; wdata = 16'h9999;
    @(negedge clk);
    req = 1'b0;
    cyc = 0;
    while (!done && cyc < 4 * TMO) begin @(negedge clk); cyc++; end
    check(mem[5] == 16'h5555, "R8", "first write stored", mem[5], 16'h5555);
    check(mem[9] == 16'hA509, "R8", "second request ignored", mem[9], 16'hA509);
    check(n_capa - a0 == 1, "R8", "single address phase", n_capa - a0, 1);

    // R7 silent PHY: timeout in the fetch-free strobe wait
    dead = 1'b1;
    access(1'b0, 16'h0003, 16'h0, cyc, to);
    check(to, "R7", "timeout flagged", {31'h0, to}, 1);
    check(cyc == 1 + SETUP + TMO, "R7", "strobe wait bound", cyc, 1 + SETUP + TMO);
    check(rdata == 16'h0, "R7", "rdata cleared", rdata, 0);
    check(cmd == 32'h0 && ready, "R7", "command zeroed", cmd, 0);
    @(negedge clk);
    check(!done && !tout, "R9", "timeout pulse one cycle", {30'h0, done, tout}, 0);
    dead = 1'b0;
    repeat (4) @(negedge clk);

    // R7 stuck acknowledge: timeout in the release wait
    stuck = 1'b1;
    access(1'b1, 16'h0004, 16'h4444, cyc, to);
    check(to, "R7", "release timeout flagged", {31'h0, to}, 1);
    check(cyc == 4 + SETUP + TMO, "R7", "release wait bound", cyc, 4 + SETUP + TMO);
    check(mem[4] == 16'hA504, "R7", "aborted write not stored", mem[4], 16'hA504);
    stuck = 1'b0;
    repeat (6) @(negedge clk);

    // recovery after timeouts
    access(1'b0, 16'h0005, 16'h0, cyc, to);
    check(!to && rdata == 16'h5555, "R4", "read after recovery", rdata, 16'h5555);
    check(err_multi == 0 && err_setup == 0, "R5", "strobe hygiene overall", err_multi + err_setup, 0);

    finish_run();
  end
endmodule